// File: doc/BRIEF.md
# Serial Flash Status and Protection Unit

This block is the status-register logic of a serial NOR flash slave on an SPI mode 0 interface. It oversamples chip select, serial clock and data in with the system clock and shifts in an 8-bit opcode. A read-status opcode makes the block stream the status byte on a tri-stated data output for as long as chip select stays low. A write-enable opcode sets the write-enable latch. The latch is set only when chip select rises after exactly eight bits.

Program and erase requests arrive as a one-cycle pulse that carries a target sector. The block accepts a request only if the write-enable latch is set, no operation is in progress, and the sector lies outside the protected region. The protected region is set by a top/bottom select bit and a 4-bit size code. Each code gives a power-of-two region that starts at the top or the bottom of the array. A request that is accepted starts a fixed busy countdown. When the countdown ends, the busy flag and the write-enable latch both clear. A request that is rejected raises a single-cycle reject pulse and does not start a busy period.

Top module: `sfs_status_unit`

## Requirements
- R1: After reset, wip_o, wel_o, spi_miso_oe_o and op_reject_o are all 0.
- R2: The status byte carries a constant 0 in bit 7, size code bit 3 in bit 6, the top/bottom select in bit 5, size code bits 2..0 in bits 4..2, the write-enable latch in bit 1 and the busy flag in bit 0.
- R3: Opcode 05h, received MSB first on rising serial clock edges, starts a status read. The status byte is then driven MSB first. Each bit changes on a falling serial clock edge and is valid at the next rising edge.
- R4: While chip select stays low after a status read opcode, the status byte repeats. Each repeat starts at bit 7 and samples the busy flag and the latch again at that moment.
- R5: spi_miso_oe_o is 0 while the opcode is shifted in and while chip select is high.
- R6: Opcode 06h sets the write-enable latch when chip select rises after exactly 8 bits. A frame that ends mid-byte, or one that carries extra clocks after the opcode, leaves the latch unchanged. A write-enable frame has no effect while busy.
- R7: A request made while the latch is 0 is rejected. op_reject_o is high for exactly the one cycle after the request, and no busy period starts.
- R8: A request made while busy is rejected with a reject pulse, and the operation in progress continues.
- R9: With the select bit at 0, code 0 protects no sector. A code n from 1 to log2(NUM_SECTORS) protects the highest 2^(n-1) sectors. Any larger code protects every sector. A request to a protected sector is rejected.
- R10: With the select bit at 1, the same codes protect regions of the same size that start at sector 0 and count upward.
- R11: An accepted request sets wip_o in the next cycle and holds it for exactly BUSY_CYCLES cycles. When wip_o falls, wel_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; it oversamples the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| spi_cs_ni | input | 1 | Chip select, active low |
| spi_sck_i | input | 1 | Serial clock, mode 0 |
| spi_mosi_i | input | 1 | Serial data in |
| spi_miso_o | output | 1 | Serial data out |
| spi_miso_oe_o | output | 1 | Output enable for the data out pin; 0 means high impedance |
| prot_tb_i | input | 1 | Protection origin: 0 = top of the array, 1 = bottom |
| prot_bp_i | input | 4 | Protection size code |
| op_req_i | input | 1 | One-cycle program or erase request |
| op_sector_i | input | log2(NUM_SECTORS) | Target sector of the request |
| op_reject_o | output | 1 | One-cycle pulse when a request is rejected |
| wip_o | output | 1 | Busy flag |
| wel_o | output | 1 | Write-enable latch |

## Verification
The assertions take for granted that requests are at least two cycles apart. This way each reject pulse can be matched to a single request. They also assume that no request lands in the final cycle of a busy period, and that chip select stays high for several system clocks between frames. The bench spaces its request pulses, waits for the busy period to be well under way before it tests rejection while busy, and holds chip select high for eight system cycles after every frame. Each serial clock half period lasts eight system cycles, so the two-stage synchroniser and the edge detector never miss an edge.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam logic [7:0] OP_RD_STAT = 8'h05;
  localparam logic [7:0] OP_WR_EN   = 8'h06;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_STAT,
    PH_WREN,
    PH_SKIP
  } phase_e;

  function automatic logic [7:0] pack_status(input logic tb, input logic [3:0] bp,
                                             input logic wel, input logic wip);
    return {1'b0, bp[3], tb, bp[2:0], wel, wip};
  endfunction
endpackage

// File: rtl/sfs_spi_front.sv
module sfs_spi_front
  import sfs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sck_i,
  input  logic       mosi_i,
  input  logic [7:0] status_i,
  output logic       miso_o,
  output logic       miso_oe_o,
  output logic       wren_o
);
  logic [2:0] cs_q, sck_q;
  logic [1:0] mosi_q;
  logic       cs_s, cs_d, sck_rise, sck_fall, mosi_s;
  phase_e     phase;
  logic [2:0] bit_cnt;
  logic [6:0] cmd_sh;
  logic [7:0] tx_sh;
  logic [7:0] cmd_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 3'b111;
      sck_q  <= 3'b000;
      mosi_q <= 2'b00;
    end else begin
      cs_q   <= {cs_q[1:0], cs_ni};
      sck_q  <= {sck_q[1:0], sck_i};
      mosi_q <= {mosi_q[0], mosi_i};
    end
  end

  assign cs_s     = cs_q[1];
  assign cs_d     = cs_q[2];
  assign sck_rise = sck_q[1] & ~sck_q[2];
  assign sck_fall = ~sck_q[1] & sck_q[2];
  assign mosi_s   = mosi_q[1];
  assign cmd_full = {cmd_sh, mosi_s};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase   <= PH_CMD;
      bit_cnt <= '0;
      cmd_sh  <= '0;
      tx_sh   <= '0;
      miso_o  <= 1'b0;
      wren_o  <= 1'b0;
    end else begin
      wren_o <= 1'b0;
      if (cs_s) begin
        // frame end: write-enable only counts after a clean 8-bit opcode
        if (!cs_d && phase == PH_WREN) wren_o <= 1'b1;
        phase   <= PH_CMD;
        bit_cnt <= '0;
      end else begin
        unique case (phase)
          PH_CMD: if (sck_rise) begin
            cmd_sh  <= cmd_full[6:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              if (cmd_full == OP_RD_STAT)    phase <= PH_STAT;
              else if (cmd_full == OP_WR_EN) phase <= PH_WREN;
              else                           phase <= PH_SKIP;
            end
          end
          PH_STAT: if (sck_fall) begin
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd0) {miso_o, tx_sh} <= {status_i, 1'b0};
            else                 {miso_o, tx_sh} <= {tx_sh, 1'b0};
          end
          PH_WREN: if (sck_rise) phase <= PH_SKIP;
          default: ;
        endcase
      end
    end
  end

  assign miso_oe_o = (phase == PH_STAT) && !cs_s;
endmodule

// File: rtl/sfs_prot_decode.sv
module sfs_prot_decode #(
  parameter int unsigned SECT_W = 9
) (
  input  logic              tb_i,
  input  logic [3:0]        bp_i,
  input  logic [SECT_W-1:0] sector_i,
  output logic              prot_o
);
  logic [SECT_W-1:0] mask;

  // bit i is part of the region index once the region spans fewer than 2^(i+1) sectors
  for (genvar i = 0; i < SECT_W; i++) begin : g_mask
    assign mask[i] = (int'(bp_i) <= i + 1);
  end

  always_comb begin
    if (bp_i == 4'd0)  prot_o = 1'b0;
    else if (tb_i)     prot_o = (sector_i & mask) == '0;
    else               prot_o = (sector_i & mask) == mask;
  end
endmodule

// File: rtl/sfs_wr_ctrl.sv
module sfs_wr_ctrl #(
  parameter int unsigned BUSY_CYCLES = 64,
  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wren_i,
  input  logic req_i,
  input  logic prot_i,
  output logic wip_o,
  output logic wel_o,
  output logic reject_o
);
  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign accept = req_i && wel_o && !wip_o && !prot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wip_o    <= 1'b0;
      wel_o    <= 1'b0;
      reject_o <= 1'b0;
      cnt      <= '0;
    end else begin
      reject_o <= req_i && !accept;
      if (wip_o) begin
        if (cnt == '0) begin
          wip_o <= 1'b0;
          wel_o <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (accept) begin
        wip_o <= 1'b1;
        cnt   <= CNT_W'(BUSY_CYCLES - 1);
      end else if (wren_i) begin
        wel_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sfs_status_unit.sv
module sfs_status_unit
  import sfs_pkg::*;
#(
  parameter int unsigned NUM_SECTORS = 512,
  parameter int unsigned BUSY_CYCLES = 64,
  localparam int unsigned SECT_W = $clog2(NUM_SECTORS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_cs_ni,
  input  logic              spi_sck_i,
  input  logic              spi_mosi_i,
  output logic              spi_miso_o,
  output logic              spi_miso_oe_o,
  input  logic              prot_tb_i,
  input  logic [3:0]        prot_bp_i,
  input  logic              op_req_i,
  input  logic [SECT_W-1:0] op_sector_i,
  output logic              op_reject_o,
  output logic              wip_o,
  output logic              wel_o
);
  logic       wren;
  logic       prot;
  logic [7:0] status;

  assign status = pack_status(prot_tb_i, prot_bp_i, wel_o, wip_o);

  sfs_spi_front u_front (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (spi_cs_ni),
    .sck_i    (spi_sck_i),
    .mosi_i   (spi_mosi_i),
    .status_i (status),
    .miso_o   (spi_miso_o),
    .miso_oe_o(spi_miso_oe_o),
    .wren_o   (wren)
  );

  sfs_prot_decode #(.SECT_W(SECT_W)) u_prot (
    .tb_i    (prot_tb_i),
    .bp_i    (prot_bp_i),
    .sector_i(op_sector_i),
    .prot_o  (prot)
  );

  sfs_wr_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_wr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wren_i  (wren),
    .req_i   (op_req_i),
    .prot_i  (prot),
    .wip_o   (wip_o),
    .wel_o   (wel_o),
    .reject_o(op_reject_o)
  );
endmodule

// File: rtl/sfs_status_unit_chk.sv
module sfs_status_unit_chk #(
  parameter int unsigned BUSY_CYCLES = 64
) (
  input logic clk_i,
  input logic rst_ni,
  input logic spi_cs_ni,
  input logic spi_miso_oe_o,
  input logic op_req_i,
  input logic op_reject_o,
  input logic wip_o,
  input logic wel_o
);
  int unsigned run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    run_cnt <= 0;
    else if (wip_o) run_cnt <= run_cnt + 1;
    else            run_cnt <= 0;
  end

  a_r5_oe_off_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_ni && $past(spi_cs_ni) && $past(spi_cs_ni, 2) && $past(spi_cs_ni, 3)
      |-> !spi_miso_oe_o);

  a_r7_no_latch_rejects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_req_i && !wel_o |=> op_reject_o && !wip_o);

  a_r7_reject_no_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_reject_o |-> !$rose(wip_o));

  a_r8_busy_rejects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_req_i && wip_o |=> op_reject_o);

  a_r11_end_clears_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip_o) |-> !wel_o);

  a_r11_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip_o) |-> run_cnt == BUSY_CYCLES);

  a_r6_latch_rises_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_o) |-> !wip_o);
endmodule

bind sfs_status_unit sfs_status_unit_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (.*);

// File: tb/sim_sfs_status_unit.sv
module sim_sfs_status_unit;
  localparam int BUSY = 200;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, sck, mosi, miso, miso_oe;
  logic       tb;
  logic [3:0] bp;
  logic       req;
  logic [8:0] sector;
  logic       reject, wip, wel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] exp_q[$];
  bit         mon_en = 0;
  int         mon_n  = 0;
  logic [7:0] mon_sh = '0;

  always #2 clk = ~clk;

  sfs_status_unit #(.NUM_SECTORS(512), .BUSY_CYCLES(BUSY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .spi_cs_ni(cs_n), .spi_sck_i(sck), .spi_mosi_i(mosi),
    .spi_miso_o(miso), .spi_miso_oe_o(miso_oe), .prot_tb_i(tb), .prot_bp_i(bp),
    .op_req_i(req), .op_sector_i(sector), .op_reject_o(reject), .wip_o(wip), .wel_o(wel)
  );

  function automatic logic [7:0] stat(input logic t, input logic [3:0] b,
                                      input logic l, input logic w);
    return {1'b0, b[3], t, b[2:0], l, w};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: assembles status bytes at rising serial clock and scores them
  always @(posedge sck) begin
    if (mon_en) begin
      mon_sh = {mon_sh[6:0], miso};
      mon_n++;
      if (!miso_oe) check("R5 oe during status", 0, 1);
      if (mon_n == 8) begin
        mon_n = 0;
        if (exp_q.size() == 0) check("R4 unexpected byte", int'(mon_sh), -1);
        else check("R3/R4 status byte", int'(mon_sh), int'(exp_q.pop_front()));
      end
    end
  end

  task automatic spi_xfer(input logic [7:0] op, input int op_bits, input int extra, input bit rd);
    int oe_bad = 0;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < op_bits; i++) begin
      mosi = op[7-i];
      repeat (HALF) @(negedge clk);
      if (miso_oe) oe_bad++;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    if (rd) begin mon_n = 0; mon_en = 1; end
    for (int i = 0; i < extra; i++) begin
      mosi = 1'b0;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    mon_en = 0;
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    check("R5 oe during opcode", oe_bad, 0);
    check("R5 oe with cs high", int'(miso_oe), 0);
  endtask

  task automatic pulse_req(input int s);
    @(negedge clk);
    sector = 9'(s);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wren();
    spi_xfer(8'h06, 8, 0, 0);
    check("R6 latch set", int'(wel), 1);
  endtask

  task automatic expect_reject(input string tag, input int s);
    pulse_req(s);
    check(tag, int'(reject), 1);
    check(tag, int'(wip), 0);
    @(negedge clk);
    check("R7 reject one cycle", int'(reject), 0);
  endtask

  task automatic run_busy(input int s);
    int n = 0;
    pulse_req(s);
    check("R11 accept no reject", int'(reject), 0);
    check("R11 wip set", int'(wip), 1);
    while (wip && n < 1000) begin n++; @(negedge clk); end
    check("R11 busy length", n, BUSY);
    check("R11 latch cleared", int'(wel), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0;
    tb = 1'b0; bp = 4'd0; req = 1'b0; sector = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    check("R1 wip", int'(wip), 0);
    check("R1 wel", int'(wel), 0);
    check("R1 oe", int'(miso_oe), 0);
    check("R1 reject", int'(reject), 0);

    // R3 R4: idle read, two repeats
    exp_q.push_back(stat(1'b0, 4'd0, 1'b0, 1'b0));
    exp_q.push_back(stat(1'b0, 4'd0, 1'b0, 1'b0));
    spi_xfer(8'h05, 8, 16, 1);
    check("R4 all bytes seen", exp_q.size(), 0);

    // R7
    expect_reject("R7 latch clear", 10);

    // R6 aborted frames
    spi_xfer(8'h06, 5, 0, 0);
    check("R6 mid-byte abort", int'(wel), 0);
    spi_xfer(8'h06, 8, 1, 0);
    check("R6 extra clock", int'(wel), 0);
    spi_xfer(8'h07, 8, 0, 0);
    check("R6 other opcode", int'(wel), 0);
    wren();

    // R2 field layout
    tb = 1'b1; bp = 4'd5;
    exp_q.push_back(stat(1'b1, 4'd5, 1'b1, 1'b0));
    spi_xfer(8'h05, 8, 8, 1);
    check("R2 byte seen", exp_q.size(), 0);
    tb = 1'b0; bp = 4'd10;
    exp_q.push_back(stat(1'b0, 4'd10, 1'b1, 1'b0));
    spi_xfer(8'h05, 8, 8, 1);
    check("R2 byte seen", exp_q.size(), 0);

    // R9 top-anchored
    tb = 1'b0; bp = 4'd1;
    expect_reject("R9 top sector", 511);
    check("R9 latch kept", int'(wel), 1);
    run_busy(510);
    wren();
    bp = 4'd9;
    expect_reject("R9 code 9 lower edge", 256);
    bp = 4'd10;
    expect_reject("R9 code 10 all", 0);
    bp = 4'd15;
    expect_reject("R9 code 15 all", 0);

    // R10 bottom-anchored
    tb = 1'b1; bp = 4'd9;
    expect_reject("R10 code 9 upper edge", 255);
    bp = 4'd3;
    expect_reject("R10 code 3 edge", 3);
    check("R10 latch kept", int'(wel), 1);

    // R8 and live status during busy (R4)
    pulse_req(4);
    check("R10 unprotected accept", int'(wip), 1);
    repeat (2) @(negedge clk);
    pulse_req(100);
    check("R8 busy reject", int'(reject), 1);
    check("R8 busy continues", int'(wip), 1);
    exp_q.push_back(stat(1'b1, 4'd3, 1'b1, 1'b1));
    exp_q.push_back(stat(1'b1, 4'd3, 1'b0, 1'b0));
    exp_q.push_back(stat(1'b1, 4'd3, 1'b0, 1'b0));
    spi_xfer(8'h05, 8, 24, 1);
    check("R4 live bytes seen", exp_q.size(), 0);
    check("R11 latch after busy", int'(wel), 0);

    // R6 write-enable during busy
    wren();
    run_busy(8);
    spi_xfer(8'h06, 8, 0, 0);
    check("R6 latch set again", int'(wel), 1);
    bp = 4'd0;
    pulse_req(0);
    check("R10 code 0 none", int'(wip), 1);
    repeat (10) @(negedge clk);
    spi_xfer(8'h06, 8, 0, 0);
    check("R6 ignored while busy", int'(wel), 1);
    while (wip) @(negedge clk);
    check("R6 busy end clears", int'(wel), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule